// File: doc/BRIEF.md
# Searchable Writeback Queue with Hazard Stall Decision

This block holds the results that an execute stage has produced but a writeback stage has not yet retired, in strict arrival order. Each record carries a two-bit kind: an arithmetic result with a destination register and a 32-bit value, a load with a destination register, a store marker, or a host marker. Execute pushes one record per cycle and writeback pops the oldest.

Every stored slot can be looked up in the same cycle. Two independent probe ports each report whether any queued arithmetic or load record targets a given register index, so both source operands of an instruction are checked together. A small decision stage combines the two probe results according to a 3-bit instruction class and raises a stall when the instruction would read a register that is still waiting to be written.

Occupancy is tracked by a three-state machine. EMPTY goes to PARTIAL on an accepted push (FILL). PARTIAL goes to FULL when a lone push takes the count to the depth (TOP_OFF), and back to EMPTY when a lone pop removes the last record (DRAIN). FULL goes to PARTIAL on a pop (RELEASE). A synchronous clear sends every state to EMPTY (FLUSH). In all other cases the state holds.

Top module: `wbq_scoreboard`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `head_valid`=0, and both probe hits are 0.
- R2: Records leave in arrival order. While the queue is non-empty, `head_tag`, `head_dest` and `head_data` show the oldest record, and `deq` removes it at the next rising edge.
- R3: Kind encoding: 0 = arithmetic result, 1 = load, 2 = store, 3 = host. A probe hits only on a queued kind-0 or kind-1 record whose destination equals the probe index. Store and host records never hit, whatever their destination field holds.
- R4: `probe_a` drives `hit_a` and `probe_b` drives `hit_b`. The two ports work independently in the same cycle.
- R5: The depth is 4. `full` rises after the fourth accepted push. A push while `full` is refused and leaves the stored records unchanged.
- R6: A pop while `empty` is ignored, and the queue stays empty.
- R7: When the queue is neither full nor empty, a push and a pop in the same cycle are both accepted and the count is unchanged. A probe never sees the record being pushed in the current cycle.
- R8: Probing register index 0 never hits, even when a record with destination 0 is queued.
- R9: `clr` empties the queue at the next edge, and it wins over a push in the same cycle. From then on both probes report no hit.
- R10: Classes 2 (two-source arithmetic or branch), 3 (store: base on A, data on B) and 4 (variable shift: value on A, amount on B) stall when `hit_a` or `hit_b` is set.
- R11: Classes 1 (one-source), 5 (immediate shift), 6 (upper-immediate, own destination on A) and 7 (register-indirect jump) stall on `hit_a` only.
- R12: Class 0 (absolute jump, jump-and-link, coprocessor read) never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush of all records |
| enq_valid | input | 1 | Push request |
| enq_tag | input | 2 | Kind of pushed record |
| enq_dest | input | 5 | Destination register of pushed record |
| enq_data | input | 32 | Result value of pushed record |
| deq | input | 1 | Pop request |
| head_valid | output | 1 | Oldest record is present |
| head_tag | output | 2 | Kind of oldest record |
| head_dest | output | 5 | Destination of oldest record |
| head_data | output | 32 | Value of oldest record |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |
| probe_a | input | 5 | Register index searched on port A |
| probe_b | input | 5 | Register index searched on port B |
| hit_a | output | 1 | Port A finds a pending write |
| hit_b | output | 1 | Port B finds a pending write |
| ins_cls | input | 3 | Instruction class for stall decision |
| stall | output | 1 | Read-after-write hazard detected |

## Verification
A wrong occupancy state shows on `full` or `empty` in the cycle after the bad edge. It then shows as a refused or phantom push, seen as a missing or stale hit on the next probe. A bad read pointer changes `head_*` at once, and a bad live mask gives a hit on a popped or refused record in the very next probe cycle. Each cycle the bench compares the hits, the stall and the head against a queue model, so any of these faults shows up within one cycle of the edge that caused it.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        TAG_ALU   = 2'd0,
        TAG_LOAD  = 2'd1,
        TAG_STORE = 2'd2,
        TAG_HOST  = 2'd3
    } wb_tag_e;

    typedef enum logic [2:0] {
        CLS_NONE      = 3'd0,
        CLS_ONE_SRC   = 3'd1,
        CLS_TWO_SRC   = 3'd2,
        CLS_STORE     = 3'd3,
        CLS_VAR_SHIFT = 3'd4,
        CLS_IMM_SHIFT = 3'd5,
        CLS_UPPER_IMM = 3'd6,
        CLS_IND_JUMP  = 3'd7
    } ins_cls_e;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    typedef struct packed {
        logic [1:0]        tag;
        logic [IDX_W-1:0]  dest;
        logic [DATA_W-1:0] data;
    } wb_rec_t;
endpackage

// File: rtl/wbq_ring.sv
module wbq_ring
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        push,
    input  logic                        pop,
    input  wb_rec_t                     in_rec,
    output wb_rec_t                     head_rec,
    output logic [DEPTH-1:0]            slot_live,
    output logic [DEPTH-1:0][1:0]       slot_tag,
    output logic [DEPTH-1:0][IDX_W-1:0] slot_dest,
    output logic                        full,
    output logic                        empty
);
    q_state_e          state, state_nx;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    wb_rec_t           mem [DEPTH];
    logic              do_push, do_pop;

    assign do_push = push && (state != Q_FULL) && !clr;
    assign do_pop  = pop && (state != Q_EMPTY) && !clr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state: FILL, TOP_OFF, DRAIN, RELEASE, FLUSH
    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = Q_EMPTY;
        end else begin
            unique case (state)
                Q_EMPTY:   if (do_push) state_nx = Q_PARTIAL;
                Q_PARTIAL: begin
                    if (do_push && !do_pop && count == CNT_W'(DEPTH - 1))
                        state_nx = Q_FULL;
                    else if (do_pop && !do_push && count == CNT_W'(1))
                        state_nx = Q_EMPTY;
                end
                Q_FULL:    if (do_pop) state_nx = Q_PARTIAL;
                default:   state_nx = Q_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    // outputs decoded from the state register
    always_comb begin
        full  = (state == Q_FULL);
        empty = (state == Q_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= in_rec;
    end

    assign head_rec = mem[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        int off;
        always_comb begin
            off = i - int'(rd_ptr);
            if (off < 0) off = off + DEPTH;
        end
        assign slot_live[i] = (off < int'(count));
        assign slot_tag[i]  = mem[i].tag;
        assign slot_dest[i] = mem[i].dest;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(wr_ptr)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (empty && $stable(rd_ptr)));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(DEPTH)) && ((count == '0) == empty));
endmodule

// File: rtl/wbq_probe.sv
module wbq_probe
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]            slot_live,
    input  logic [DEPTH-1:0][1:0]       slot_tag,
    input  logic [DEPTH-1:0][IDX_W-1:0] slot_dest,
    input  logic [IDX_W-1:0]            probe,
    output logic                        hit
);
    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic writes_reg;
        assign writes_reg = (slot_tag[i] == 2'(TAG_ALU)) || (slot_tag[i] == 2'(TAG_LOAD));
        assign match[i]   = slot_live[i] && writes_reg && (slot_dest[i] == probe);
    end

    assign hit = (|match) && (probe != '0);
endmodule

// File: rtl/wbq_stall.sv
module wbq_stall
    import wbq_pkg::*;
(
    input  logic [2:0] ins_cls,
    input  logic       hit_a,
    input  logic       hit_b,
    output logic       stall
);
    ins_cls_e cls;
    assign cls = ins_cls_e'(ins_cls);

    always_comb begin
        unique case (cls)
            CLS_NONE:                                stall = 1'b0;
            CLS_TWO_SRC, CLS_STORE, CLS_VAR_SHIFT:   stall = hit_a || hit_b;
            CLS_ONE_SRC, CLS_IMM_SHIFT,
            CLS_UPPER_IMM, CLS_IND_JUMP:             stall = hit_a;
            default:                                 stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/wbq_scoreboard.sv
module wbq_scoreboard
    import wbq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              enq_valid,
    input  logic [1:0]        enq_tag,
    input  logic [IDX_W-1:0]  enq_dest,
    input  logic [DATA_W-1:0] enq_data,
    input  logic              deq,
    output logic              head_valid,
    output logic [1:0]        head_tag,
    output logic [IDX_W-1:0]  head_dest,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    input  logic [IDX_W-1:0]  probe_a,
    input  logic [IDX_W-1:0]  probe_b,
    output logic              hit_a,
    output logic              hit_b,
    input  logic [2:0]        ins_cls,
    output logic              stall
);
    localparam int N_PORTS = 2;

    wb_rec_t                      in_rec, head_rec;
    logic [DEPTH-1:0]             slot_live;
    logic [DEPTH-1:0][1:0]        slot_tag;
    logic [DEPTH-1:0][IDX_W-1:0]  slot_dest;
    logic [N_PORTS-1:0][IDX_W-1:0] probe_v;
    logic [N_PORTS-1:0]           hit_v;

    assign in_rec = '{tag: enq_tag, dest: enq_dest, data: enq_data};

    wbq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (enq_valid),
        .pop       (deq),
        .in_rec    (in_rec),
        .head_rec  (head_rec),
        .slot_live (slot_live),
        .slot_tag  (slot_tag),
        .slot_dest (slot_dest),
        .full      (full),
        .empty     (empty)
    );

    assign probe_v = {probe_b, probe_a};

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        wbq_probe #(.DEPTH(DEPTH)) u_probe (
            .slot_live (slot_live),
            .slot_tag  (slot_tag),
            .slot_dest (slot_dest),
            .probe     (probe_v[p]),
            .hit       (hit_v[p])
        );
    end

    assign hit_a = hit_v[0];
    assign hit_b = hit_v[1];

    wbq_stall u_stall (
        .ins_cls (ins_cls),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .stall   (stall)
    );

    assign head_valid = !empty;
    assign head_tag   = head_rec.tag;
    assign head_dest  = head_rec.dest;
    assign head_data  = head_rec.data;

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !hit_a && !hit_b));

    // R8
    zero_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((probe_a == '0) |-> !hit_a) and ((probe_b == '0) |-> !hit_b));

    // R12
    none_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_cls == 3'd0) |-> !stall);

    // R1
    empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!hit_a && !hit_b && !full));
endmodule

// File: tb/sim_wbq_scoreboard.sv
module sim_wbq_scoreboard;
    typedef struct {
        logic [1:0]  tag;
        logic [4:0]  dest;
        logic [31:0] data;
    } m_rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, enq_valid = 1'b0, deq = 1'b0;
    logic [1:0]  enq_tag = '0;
    logic [4:0]  enq_dest = '0, probe_a = '0, probe_b = '0;
    logic [31:0] enq_data = '0;
    logic [2:0]  ins_cls = '0;
    logic        head_valid, full, empty, hit_a, hit_b, stall;
    logic [1:0]  head_tag;
    logic [4:0]  head_dest;
    logic [31:0] head_data;

    int n_chk = 0, n_fail = 0;
    m_rec_t m_q[$];

    always #10 clk = ~clk;

    wbq_scoreboard u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .enq_valid(enq_valid),
        .enq_tag(enq_tag), .enq_dest(enq_dest), .enq_data(enq_data), .deq(deq),
        .head_valid(head_valid), .head_tag(head_tag), .head_dest(head_dest),
        .head_data(head_data), .full(full), .empty(empty), .probe_a(probe_a),
        .probe_b(probe_b), .hit_a(hit_a), .hit_b(hit_b), .ins_cls(ins_cls),
        .stall(stall)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic m_hit(input logic [4:0] r);
        if (r == 5'd0) return 1'b0;
        foreach (m_q[i])
            if ((m_q[i].tag == 2'd0 || m_q[i].tag == 2'd1) && m_q[i].dest == r)
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic m_stall(input logic [2:0] k, input logic ha, input logic hb);
        case (k)
            3'd0:             return 1'b0;
            3'd2, 3'd3, 3'd4: return ha || hb;
            default:          return ha;
        endcase
    endfunction

    // driver: apply one cycle, monitor compares outputs with the model, then the model advances
    task automatic step(input logic e, input logic [1:0] t, input logic [4:0] d,
                        input logic [31:0] v, input logic p, input logic c,
                        input logic [4:0] a, input logic [4:0] b,
                        input logic [2:0] k, input string req);
        logic ea, eb;
        @(negedge clk);
        enq_valid = e; enq_tag = t; enq_dest = d; enq_data = v;
        deq = p; clr = c; probe_a = a; probe_b = b; ins_cls = k;
        #1;
        ea = m_hit(a);
        eb = m_hit(b);
        check(req, "hit_a", 32'(hit_a), 32'(ea));
        check(req, "hit_b", 32'(hit_b), 32'(eb));
        check(req, "stall", 32'(stall), 32'(m_stall(k, ea, eb)));
        check(req, "full",  32'(full),  32'(m_q.size() == 4));
        check(req, "empty", 32'(empty), 32'(m_q.size() == 0));
        if (m_q.size() > 0) begin
            check(req, "head_tag",  32'(head_tag),  32'(m_q[0].tag));
            check(req, "head_dest", 32'(head_dest), 32'(m_q[0].dest));
            check(req, "head_data", head_data, m_q[0].data);
        end
        @(posedge clk);
        if (c) begin
            m_q.delete();
        end else begin
            logic pop_ok, push_ok;
            pop_ok  = p && (m_q.size() > 0);
            push_ok = e && (m_q.size() < 4);
            if (pop_ok) void'(m_q.pop_front());
            if (push_ok) m_q.push_back('{tag: t, dest: d, data: v});
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "head_valid", 32'(head_valid), 32'd0);
        step(0, 0, 0, 0, 0, 0, 5'd5, 5'd7, 3'd2, "R1");
        // R7 push of r5 not visible in same cycle
        step(1, 2'd0, 5'd5, 32'hDEAD_0005, 0, 0, 5'd5, 5'd0, 3'd1, "R7");
        // R4 / R10 two-source: a hits, b (load being pushed) not yet
        step(1, 2'd1, 5'd7, 32'h0, 0, 0, 5'd5, 5'd7, 3'd2, "R10");
        // R10 store class, b hits
        step(1, 2'd2, 5'd9, 32'h99, 0, 0, 5'd9, 5'd7, 3'd3, "R10");
        // R3 store record with dest 9 must not hit; variable shift
        step(1, 2'd3, 5'd10, 32'hAA, 0, 0, 5'd9, 5'd10, 3'd4, "R3");
        // R5 full, push refused; R11 immediate shift ignores port B
        step(1, 2'd0, 5'd12, 32'h12, 0, 0, 5'd10, 5'd5, 3'd5, "R5");
        // R5 refused r12 absent; R11 upper-immediate on A only
        step(0, 0, 0, 0, 0, 0, 5'd12, 5'd7, 3'd6, "R11");
        // R12 class 0 never stalls even with both hits
        step(0, 0, 0, 0, 0, 0, 5'd7, 5'd5, 3'd0, "R12");
        // R11 indirect jump on A
        step(0, 0, 0, 0, 0, 0, 5'd5, 5'd0, 3'd7, "R11");
        // pop while full with push: push refused
        step(1, 2'd0, 5'd20, 32'h20, 1, 0, 5'd5, 5'd0, 3'd1, "R2");
        // R2 oldest removed, r20 refused
        step(0, 0, 0, 0, 1, 0, 5'd5, 5'd20, 3'd2, "R2");
        step(0, 0, 0, 0, 1, 0, 5'd7, 5'd9, 3'd3, "R2");
        step(0, 0, 0, 0, 1, 0, 5'd7, 5'd10, 3'd2, "R2");
        // R6 pop on empty ignored
        step(0, 0, 0, 0, 1, 0, 5'd10, 5'd7, 3'd2, "R6");
        step(1, 2'd0, 5'd0, 32'h1234, 0, 0, 5'd0, 5'd0, 3'd2, "R6");
        // R8 dest 0 queued, probe 0 must not hit
        step(0, 0, 0, 0, 0, 0, 5'd0, 5'd0, 3'd2, "R8");
        // R7 simultaneous push and pop at count 1
        step(1, 2'd1, 5'd3, 32'h0, 1, 0, 5'd3, 5'd0, 3'd1, "R7");
        step(1, 2'd0, 5'd4, 32'h44, 0, 0, 5'd3, 5'd4, 3'd2, "R7");
        step(1, 2'd0, 5'd6, 32'h66, 0, 0, 5'd4, 5'd6, 3'd2, "R4");
        // R9 flush with a push in the same cycle
        step(1, 2'd0, 5'd8, 32'h88, 0, 1, 5'd3, 5'd6, 3'd2, "R9");
        step(0, 0, 0, 0, 0, 0, 5'd8, 5'd3, 3'd2, "R9");
        step(0, 0, 0, 0, 0, 0, 5'd4, 5'd6, 3'd4, "R9");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule